// File: doc/BRIEF.md
# Alpha-Blend Pixel Read-Modify-Write Unit

This unit sits between a pixel generator and a frame buffer memory port. It takes one pixel at a time from a valid/ready stream. Each pixel carries a frame buffer address, a 24-bit draw colour and a 3-bit coverage value (alpha, 0 to 7). For a partly transparent pixel the unit reads the colour already stored at that address and mixes the two colours one channel at a time. It then writes the mixed colour back to the same address. The mix gives weight alpha/7 to the draw colour and (7-alpha)/7 to the stored colour.

The two extreme alphas skip work. Alpha 7 writes the draw colour straight away, with no read. Alpha 0 is accepted and dropped, with no memory access. The read port has a fixed latency of one cycle.

The controller has four states:
- ST_IDLE: waiting for a pixel.
- ST_READ: the read strobe is driven.
- ST_MIX: the read data is captured and mixed into the result register.
- ST_WRITE: the write strobe is driven.

Its transitions are:
- ST_IDLE or ST_WRITE to ST_IDLE: no pixel arrives, or an alpha-0 pixel is taken.
- ST_IDLE or ST_WRITE to ST_WRITE: an alpha-7 pixel is taken.
- ST_IDLE or ST_WRITE to ST_READ: a pixel with alpha 1 to 6 is taken.
- ST_READ to ST_MIX, and ST_MIX to ST_WRITE: always.

A new pixel may be taken in the same cycle as the write-back of the previous one.

Top module: `pix_blend_rmw`

## Requirements
- R1: While reset (rst_n low) is asserted, and in the first cycle after it, in_ready is 1, and mem_rd_en and mem_wr_en are 0.
- R2: For alpha a in 1..6, each 8-bit channel of the written colour equals floor((a*draw + (7-a)*orig + 3)/7). Channels are packed red [23:16], green [15:8], blue [7:0], and each is computed independently.
- R3: A pixel with alpha 1..6 accepted at clock edge t gives mem_rd_en for one cycle after edge t, at the pixel address. The read data is sampled one cycle after the strobe. mem_wr_en follows for one cycle after edge t+2, at the same address.
- R4: A pixel with alpha 7 makes no read. It gives mem_wr_en in the cycle after acceptance, with the draw colour unchanged.
- R5: A pixel with alpha 0 is accepted in one cycle, with no read and no write, so the stored colour is unchanged.
- R6: in_ready is 0 in the read and mix cycles. It is 1 when idle and during the write-back cycle, and a pixel may be accepted in that write-back cycle.
- R7: A pixel that follows another at the same address reads the value the first one wrote, not the older value.
- R8: mem_rd_en and mem_wr_en are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel request valid |
| in_ready | output | 1 | Unit can take a pixel |
| in_addr | input | ADDR_W | Frame buffer address of the pixel |
| in_color | input | 3*CH_W | Draw colour, red high, blue low |
| in_alpha | input | A_W | Coverage, 0 transparent to 7 opaque |
| mem_rd_en | output | 1 | Read strobe |
| mem_rd_addr | output | ADDR_W | Read address |
| mem_rd_data | input | 3*CH_W | Read data, valid one cycle after the strobe |
| mem_wr_en | output | 1 | Write strobe |
| mem_wr_addr | output | ADDR_W | Write address |
| mem_wr_data | output | 3*CH_W | Blended colour to store |

## Verification
The write-back of one pixel can fall in the same cycle as the acceptance of the next pixel. This matters most when both pixels target the same address. The bench holds a second blended pixel for the same address valid while the first is in flight. It then confirms three things:
- in_ready rises exactly in the write cycle.
- The second read strobe appears in the very next cycle.
- The final stored colour equals the first blend fed into the second blend.

A stale read would leave the single-blend value in memory and would be reported.

// File: rtl/pbr_pkg.sv
package pbr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_MIX   = 2'd2,
        ST_WRITE = 2'd3
    } pbr_state_e;
endpackage

// File: rtl/pbr_lane.sv
module pbr_lane #(
    parameter int CH_W = 8,
    parameter int A_W  = 3
) (
    input  logic [A_W-1:0]  alpha,
    input  logic [CH_W-1:0] draw,
    input  logic [CH_W-1:0] orig,
    output logic [CH_W-1:0] mixed
);
    localparam int A_MAX  = (1 << A_W) - 1;
    localparam int SUM_W  = CH_W + A_W + 1;
    localparam int SHIFT  = CH_W + A_W + 3;
    localparam int PROD_W = SUM_W + SHIFT + 1;
    localparam int BIAS   = (A_MAX - 1) / 2;
    localparam int RECIP  = ((1 << SHIFT) + A_MAX - 1) / A_MAX;
    localparam logic [A_W-1:0] A_TOP = '1;

    logic [A_W-1:0]    inv_a;
    logic [SUM_W-1:0]  sum;
    logic [PROD_W-1:0] prod;

    always_comb begin
        inv_a = A_TOP - alpha;
        sum   = SUM_W'(alpha) * SUM_W'(draw)
              + SUM_W'(inv_a) * SUM_W'(orig)
              + SUM_W'(BIAS);
        prod  = PROD_W'(sum) * PROD_W'(RECIP);
        mixed = prod[SHIFT +: CH_W];
    end

    // R2: a weighted mean never leaves the range spanned by its two inputs
    always_comb begin
        if (alpha != '0 && alpha != A_TOP) begin
            p_mix_bounded_r2: assert (
                (mixed >= ((draw < orig) ? draw : orig)) &&
                (mixed <= ((draw > orig) ? draw : orig)))
            else $error("mixed channel outside input range");
        end
    end
endmodule

// File: rtl/pbr_mixer.sv
module pbr_mixer #(
    parameter int CH_W = 8,
    parameter int A_W  = 3,
    parameter int N_CH = 3
) (
    input  logic [A_W-1:0]       alpha,
    input  logic [N_CH*CH_W-1:0] draw,
    input  logic [N_CH*CH_W-1:0] orig,
    output logic [N_CH*CH_W-1:0] mixed
);
    for (genvar g = 0; g < N_CH; g++) begin : g_lane
        pbr_lane #(.CH_W(CH_W), .A_W(A_W)) u_lane (
            .alpha (alpha),
            .draw  (draw[g*CH_W +: CH_W]),
            .orig  (orig[g*CH_W +: CH_W]),
            .mixed (mixed[g*CH_W +: CH_W])
        );
    end
endmodule

// File: rtl/pix_blend_rmw.sv
module pix_blend_rmw #(
    parameter int ADDR_W = 16,
    parameter int CH_W   = 8,
    parameter int A_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [ADDR_W-1:0]   in_addr,
    input  logic [3*CH_W-1:0]   in_color,
    input  logic [A_W-1:0]      in_alpha,
    output logic                mem_rd_en,
    output logic [ADDR_W-1:0]   mem_rd_addr,
    input  logic [3*CH_W-1:0]   mem_rd_data,
    output logic                mem_wr_en,
    output logic [ADDR_W-1:0]   mem_wr_addr,
    output logic [3*CH_W-1:0]   mem_wr_data
);
    import pbr_pkg::*;

    localparam int PIX_W = 3 * CH_W;
    localparam logic [A_W-1:0] A_TOP = '1;

    pbr_state_e        state, state_nx;
    logic [ADDR_W-1:0] addr_q;
    logic [PIX_W-1:0]  color_q;
    logic [A_W-1:0]    alpha_q;
    logic [PIX_W-1:0]  result_q;
    logic [PIX_W-1:0]  mix_out;
    logic              take;

    assign take = in_valid && in_ready;

    // next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_WRITE: begin
                if (!take || in_alpha == '0) state_nx = ST_IDLE;
                else if (in_alpha == A_TOP)  state_nx = ST_WRITE;
                else                         state_nx = ST_READ;
            end
            ST_READ: state_nx = ST_MIX;
            ST_MIX:  state_nx = ST_WRITE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // outputs
    always_comb begin
        in_ready    = 1'b0;
        mem_rd_en   = 1'b0;
        mem_wr_en   = 1'b0;
        unique case (state)
            ST_IDLE:  in_ready = 1'b1;
            ST_READ:  mem_rd_en = 1'b1;
            ST_MIX:   ;
            ST_WRITE: begin
                in_ready  = 1'b1;
                mem_wr_en = 1'b1;
            end
            default:  ;
        endcase
        mem_rd_addr = addr_q;
        mem_wr_addr = addr_q;
        mem_wr_data = result_q;
    end

    pbr_mixer #(.CH_W(CH_W), .A_W(A_W), .N_CH(3)) u_mix (
        .alpha (alpha_q),
        .draw  (color_q),
        .orig  (mem_rd_data),
        .mixed (mix_out)
    );

    // pixel and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            color_q  <= '0;
            alpha_q  <= '0;
            result_q <= '0;
        end else begin
            if (take) begin
                addr_q  <= in_addr;
                color_q <= in_color;
                alpha_q <= in_alpha;
                if (in_alpha == A_TOP) result_q <= in_color;
            end
            if (state == ST_MIX) result_q <= mix_out;
        end
    end

    // R8: never read and write in one cycle
    p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    // R3: read is followed two cycles later by a write to the same address
    p_read_then_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> ##2 (mem_wr_en && mem_wr_addr == $past(mem_rd_addr, 2)));

    // R6: no pixel is taken while a read is outstanding
    p_stall_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !in_ready);

    // R4: opaque pixel written directly without a read
    p_opaque_direct_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_alpha == A_TOP) |=>
            (mem_wr_en && !mem_rd_en && mem_wr_data == $past(in_color)
             && mem_wr_addr == $past(in_addr)));

    // R5: transparent pixel touches no memory
    p_clear_dropped_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_alpha == '0) |=> (!mem_rd_en && !mem_wr_en));
endmodule

// File: tb/sim_pix_blend_rmw.sv
`timescale 1ns/100ps
module sim_pix_blend_rmw;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_addr = '0;
    logic [23:0] in_color = '0;
    logic [2:0]  in_alpha = '0;
    logic        mem_rd_en;
    logic [15:0] mem_rd_addr;
    logic [23:0] mem_rd_data;
    logic        mem_wr_en;
    logic [15:0] mem_wr_addr;
    logic [23:0] mem_wr_data;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pix_blend_rmw u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_color(in_color), .in_alpha(in_alpha),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    // frame buffer model with one-cycle read latency and a preload path
    logic [23:0] fb [64];
    logic        pre_en = 1'b0;
    logic [5:0]  pre_addr = '0;
    logic [23:0] pre_data = '0;
    int rd_cnt = 0;
    int wr_cnt = 0;

    always @(posedge clk) begin
        if (pre_en) fb[pre_addr] <= pre_data;
        else if (mem_wr_en) fb[mem_wr_addr[5:0]] <= mem_wr_data;
        if (mem_rd_en) mem_rd_data <= fb[mem_rd_addr[5:0]];
        if (rst_n && mem_rd_en) rd_cnt <= rd_cnt + 1;
        if (rst_n && mem_wr_en) wr_cnt <= wr_cnt + 1;
    end

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !finished) begin
            finished = 1'b1;
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: act=timeout exp=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] blend(input logic [23:0] o, input logic [23:0] d,
                                          input logic [2:0] a);
        logic [23:0] r;
        for (int c = 0; c < 3; c++) begin
            int s;
            s = int'(a) * int'(d[c*8 +: 8]) + (7 - int'(a)) * int'(o[c*8 +: 8]) + 3;
            r[c*8 +: 8] = 8'(s / 7);
        end
        return r;
    endfunction

    task automatic preload(input logic [5:0] a, input logic [23:0] v);
        @(negedge clk);
        pre_en = 1'b1; pre_addr = a; pre_data = v;
        @(negedge clk);
        pre_en = 1'b0;
    endtask

    task automatic push(input logic [5:0] a, input logic [23:0] col, input logic [2:0] al);
        @(negedge clk);
        in_valid = 1'b1; in_addr = {10'd0, a}; in_color = col; in_alpha = al;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // {addr[5:0], orig[23:0], draw[23:0], alpha[2:0]}
    localparam logic [56:0] VEC [8] = '{
        {6'd1, 24'h000000, 24'hFFFFFF, 3'd1},
        {6'd2, 24'hFF8000, 24'h00FF40, 3'd2},
        {6'd3, 24'h123456, 24'hABCDEF, 3'd3},
        {6'd4, 24'hFFFFFF, 24'h000000, 3'd4},
        {6'd5, 24'h808080, 24'h7F7F7F, 3'd5},
        {6'd6, 24'h0A1B2C, 24'hF0E0D0, 3'd6},
        {6'd7, 24'h55AA55, 24'h010203, 3'd7},
        {6'd8, 24'h336699, 24'hFFFFFF, 3'd0}
    };

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 ready in reset", 32'(in_ready), 32'd1);
        chk("R1 rd_en in reset", 32'(mem_rd_en), 32'd0);
        chk("R1 wr_en in reset", 32'(mem_wr_en), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", 32'(in_ready), 32'd1);
        chk("R1 strobes after reset", 32'({mem_rd_en, mem_wr_en}), 32'd0);

        // vector table: R2 blend, R4 opaque, R5 transparent
        for (int i = 0; i < 8; i++) begin
            logic [5:0]  va;
            logic [23:0] vo, vd, exp_v;
            logic [2:0]  val;
            int r0, w0, er, ew;
            va = VEC[i][56:51]; vo = VEC[i][50:27]; vd = VEC[i][26:3]; val = VEC[i][2:0];
            preload(va, vo);
            r0 = rd_cnt; w0 = wr_cnt;
            push(va, vd, val);
            repeat (4) @(negedge clk);
            if (val == 3'd0)      begin exp_v = vo; er = 0; ew = 0; end
            else if (val == 3'd7) begin exp_v = vd; er = 0; ew = 1; end
            else                  begin exp_v = blend(vo, vd, val); er = 1; ew = 1; end
            chk((val == 0) ? "R5 stored colour" : (val == 7) ? "R4 stored colour" : "R2 blended colour",
                32'(fb[va]), 32'(exp_v));
            chk((val == 0) ? "R5 read count" : (val == 7) ? "R4 read count" : "R3 read count",
                32'(rd_cnt - r0), 32'(er));
            chk((val == 0) ? "R5 write count" : (val == 7) ? "R4 write count" : "R3 write count",
                32'(wr_cnt - w0), 32'(ew));
        end

        // R4 timing: write in the cycle after acceptance
        @(negedge clk);
        in_valid = 1'b1; in_addr = 16'd20; in_color = 24'hC0FFEE; in_alpha = 3'd7;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R4 write next cycle", 32'(mem_wr_en), 32'd1);
        chk("R4 write data", 32'(mem_wr_data), 32'hC0FFEE);
        chk("R4 no read", 32'(mem_rd_en), 32'd0);
        repeat (3) @(negedge clk);

        // R3, R6, R7, R8: back-to-back blended pixels on one address
        preload(6'd30, 24'h204060);
        @(negedge clk);
        in_valid = 1'b1; in_addr = 16'd30; in_color = 24'hE0A010; in_alpha = 3'd3;
        @(negedge clk);
        in_color = 24'h0080FF; in_alpha = 3'd5;
        chk("R3 read strobe", 32'(mem_rd_en), 32'd1);
        chk("R3 read address", 32'(mem_rd_addr), 32'd30);
        chk("R6 ready low in read", 32'(in_ready), 32'd0);
        @(negedge clk);
        chk("R6 ready low in mix", 32'(in_ready), 32'd0);
        chk("R8 no strobe in mix", 32'({mem_rd_en, mem_wr_en}), 32'd0);
        @(negedge clk);
        chk("R3 write strobe", 32'(mem_wr_en), 32'd1);
        chk("R3 write address", 32'(mem_wr_addr), 32'd30);
        chk("R3 write data", 32'(mem_wr_data), 32'(blend(24'h204060, 24'hE0A010, 3'd3)));
        chk("R6 ready in write", 32'(in_ready), 32'd1);
        chk("R8 no read with write", 32'(mem_rd_en), 32'd0);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R6 accepted in write cycle", 32'(mem_rd_en), 32'd1);
        repeat (4) @(negedge clk);
        chk("R7 chained blend", 32'(fb[30]),
            32'(blend(blend(24'h204060, 24'hE0A010, 3'd3), 24'h0080FF, 3'd5)));

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule